// File: doc/BRIEF.md
# RAM-Backed Multi-Tap Delay Line

This block delays a stream of `WIDTH`-bit words through `TAPS` equal sections, each `STAGES` positions long. The words are held in small RAM segments, one per section, rather than in flip-flops. A circular pointer walks through the segments once per enabled clock. Each segment is read on the rising edge and written on the falling edge of that clock. One shift therefore finishes in a single cycle, and every section's output is available at the same time.

Typical uses are filter delay lines, correlators and multi-channel sample buffers, where many delayed copies of one stream are needed and flip-flop chains would cost too much. The output of the deepest section is brought out on its own port, so it can feed `din` of a second instance to make a longer line. When the pipeline has filled, a flag shows that even the deepest tap holds data taken after reset. At elaboration the block rejects a configuration whose total storage is more than 4608 bits, or whose parallel tap bus is 36 bits or wider.

Top module: `ram_tap_delay`

## Requirements
- R1: After each clock edge with `shift_en` high (an enabled shift), tap k (k = 1..TAPS) holds the `din` word accepted k·STAGES enabled shifts earlier. Clocks with `shift_en` low are not counted.
- R2: After an enabled shift, tap k+1 equals the value that tap k showed after the enabled shift STAGES shifts earlier, so each section feeds the next one.
- R3: A clock edge with `shift_en` low leaves `taps_out`, `last_tap` and `taps_valid` unchanged and alters no stored word. When shifting resumes, the delayed sequence continues with no gap and no repeat.
- R4: In `taps_out`, tap k occupies bits [k·WIDTH−1 : (k−1)·WIDTH], with tap 1 in the least significant slice. `last_tap` carries tap TAPS.
- R5: A rising edge with `rst` high sets `taps_out` and `last_tap` to zero, drives `taps_valid` low, returns the pointer to its first address and restarts the fill count. `shift_en` is ignored during reset.
- R6: `taps_valid` goes high at the edge of the (STAGES·TAPS+1)-th enabled shift after reset and stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; reads on the rising edge, RAM writes on the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | Advances the line by one position on this rising edge |
| din | input | WIDTH | Word entering the first section |
| taps_out | output | TAPS·WIDTH | All tap outputs side by side, tap 1 in the low slice |
| last_tap | output | WIDTH | Output of the deepest tap, for cascading |
| taps_valid | output | 1 | High once every tap holds data accepted after reset |

## Verification
On every cycle the assertions check the following: the outputs freeze while `shift_en` is low, reset clears the outputs, the valid flag stays high once set, and the valid flag rises only on an enabled shift, in the cycle that an independent shift counter predicts. Delay depth, the section-to-section hand-off and the absence of stray RAM writes during idle cycles depend on data several wraps of the pointer back. Only the bench's scenarios can show these. The bench compares each tap with a history of accepted words over bursts, random gaps, idle runs and a reset in mid-stream.

// File: rtl/ram_tap_pkg.sv
package ram_tap_pkg;
  // capacity of one embedded memory and of its widest read port
  localparam int unsigned RAM_BIT_LIMIT  = 4608;
  localparam int unsigned PORT_BIT_LIMIT = 36;

  // address width that stays legal for a single-entry segment
  function automatic int unsigned addr_bits(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/tap_addr_ctr.sv
module tap_addr_ctr #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned FILL  = 64,
  parameter int unsigned AW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          full
);
  localparam int unsigned CW = $clog2(FILL + 1);

  logic [CW-1:0] fill_cnt;

  // circular pointer: wraps after DEPTH positions
  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (step) begin
      if (addr == AW'(DEPTH - 1)) addr <= '0;
      else                        addr <= addr + 1'b1;
    end
  end

  // counts enabled shifts up to FILL; the next shift marks the line full
  always_ff @(posedge clk) begin
    if (rst) begin
      fill_cnt <= '0;
      full     <= 1'b0;
    end else if (step) begin
      if (fill_cnt != CW'(FILL)) fill_cnt <= fill_cnt + 1'b1;
      else                       full     <= 1'b1;
    end
  end
endmodule

// File: rtl/tap_segment_ram.sv
module tap_segment_ram #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  q
);
  logic [W-1:0] mem [DEPTH];

  // write half: second half of the cycle
  always_ff @(negedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // registered read on the rising edge
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (rd_en) q <= mem[rd_addr];
  end
endmodule

// File: rtl/ram_tap_delay.sv
module ram_tap_delay #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 16,
  parameter int unsigned TAPS   = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    shift_en,
  input  logic [WIDTH-1:0]        din,
  output logic [TAPS*WIDTH-1:0]   taps_out,
  output logic [WIDTH-1:0]        last_tap,
  output logic                    taps_valid
);
  import ram_tap_pkg::*;

  localparam int unsigned AW         = addr_bits(STAGES);
  localparam int unsigned FILL       = STAGES * TAPS;
  localparam int unsigned TOTAL_BITS = WIDTH * STAGES * TAPS;
  localparam int unsigned PORT_BITS  = WIDTH * TAPS;

  if (TOTAL_BITS > RAM_BIT_LIMIT) begin : g_cap_store
    $error("delay line storage exceeds one memory block");
  end
  if (PORT_BITS >= PORT_BIT_LIMIT) begin : g_cap_port
    $error("parallel tap width exceeds the memory port");
  end

  logic             step;
  logic [AW-1:0]    rd_addr;
  logic [AW-1:0]    wr_addr_q;
  logic             wr_en_q;
  logic [WIDTH-1:0] din_q;
  logic [WIDTH-1:0] tap_q [TAPS];

  assign step = shift_en & ~rst;

  tap_addr_ctr #(
    .DEPTH (STAGES),
    .FILL  (FILL),
    .AW    (AW)
  ) u_ctr (
    .clk  (clk),
    .rst  (rst),
    .step (step),
    .addr (rd_addr),
    .full (taps_valid)
  );

  // capture the write half of this shift for the falling edge
  always_ff @(posedge clk) begin
    if (rst) wr_en_q <= 1'b0;
    else     wr_en_q <= step;
    wr_addr_q <= rd_addr;
    din_q     <= din;
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_seg
    logic [WIDTH-1:0] seg_src;
    if (k == 0) begin : g_head
      assign seg_src = din_q;
    end else begin : g_link
      assign seg_src = tap_q[k-1];
    end

    tap_segment_ram #(
      .W     (WIDTH),
      .DEPTH (STAGES),
      .AW    (AW)
    ) u_seg (
      .clk     (clk),
      .rst     (rst),
      .rd_en   (step),
      .rd_addr (rd_addr),
      .wr_en   (wr_en_q),
      .wr_addr (wr_addr_q),
      .wr_data (seg_src),
      .q       (tap_q[k])
    );

    assign taps_out[k*WIDTH +: WIDTH] = tap_q[k];
  end

  assign last_tap = tap_q[TAPS-1];
endmodule

// File: rtl/ram_tap_checker.sv
module ram_tap_checker #(
  parameter int unsigned W = 8,
  parameter int unsigned M = 16,
  parameter int unsigned N = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           shift_en,
  input logic [N*W-1:0] taps_out,
  input logic [W-1:0]   last_tap,
  input logic           taps_valid
);
  localparam int unsigned LIM = M * N + 1;
  localparam int unsigned CW  = $clog2(LIM + 1);

  logic [CW-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst)                                seen <= '0;
    else if (shift_en && seen != CW'(LIM))  seen <= seen + 1'b1;
  end

  AST_IDLE_HOLD_TAPS: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(taps_out)); // R3
  AST_IDLE_HOLD_LAST: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> ($stable(last_tap) && $stable(taps_valid))); // R3
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (taps_out == '0 && last_tap == '0 && !taps_valid)); // R5
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
    taps_valid |=> taps_valid); // R6
  AST_VALID_ON_SHIFT: assert property (@(posedge clk) disable iff (rst)
    $rose(taps_valid) |-> $past(shift_en)); // R6
  AST_VALID_WINDOW: assert property (@(posedge clk) disable iff (rst)
    taps_valid == (seen == CW'(LIM))); // R6
endmodule

bind ram_tap_delay ram_tap_checker #(
  .W (WIDTH),
  .M (STAGES),
  .N (TAPS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .shift_en   (shift_en),
  .taps_out   (taps_out),
  .last_tap   (last_tap),
  .taps_valid (taps_valid)
);

// File: tb/sim_ram_tap_delay.sv
`timescale 1ns/1ps
module sim_ram_tap_delay;
  localparam int W    = 8;
  localparam int M    = 5;
  localparam int N    = 3;
  localparam int HMAX = 8192;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           shift_en = 1'b0;
  logic [W-1:0]   din = '0;
  logic [N*W-1:0] taps_out;
  logic [W-1:0]   last_tap;
  logic           taps_valid;

  always #4 clk = ~clk;

  ram_tap_delay #(.WIDTH(W), .STAGES(M), .TAPS(N)) u0 (
    .clk(clk), .rst(rst), .shift_en(shift_en), .din(din),
    .taps_out(taps_out), .last_tap(last_tap), .taps_valid(taps_valid)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int j      = 0;
  logic [W-1:0]   hist [HMAX];
  logic [N*W-1:0] obs  [HMAX];
  logic [N*W-1:0] prv_taps;
  logic [W-1:0]   prv_last;
  logic           prv_valid;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive one clock, then check at the following falling edge
  task automatic cycle(input bit r, input bit en, input logic [W-1:0] d);
    rst = r; shift_en = en; din = d;
    @(negedge clk);
    if (r) begin
      j = 0;
      chk(taps_out == '0, "R5", "taps after reset", taps_out, 0);
      chk(last_tap == '0, "R5", "last after reset", last_tap, 0);
      chk(!taps_valid,    "R5", "valid after reset", taps_valid, 0);
    end else if (en && j < HMAX - 1) begin
      j++;
      hist[j] = d;
      obs[j]  = taps_out;
      for (int k = 1; k <= N; k++) begin
        if (j > k * M)
          chk(taps_out[(k-1)*W +: W] == hist[j-k*M], "R1", $sformatf("tap %0d", k),
              taps_out[(k-1)*W +: W], hist[j-k*M]);
      end
      for (int k = 1; k < N; k++) begin
        if (j - M > k * M)
          chk(taps_out[k*W +: W] == obs[j-M][(k-1)*W +: W], "R2",
              $sformatf("tap %0d fed by tap %0d", k + 1, k),
              taps_out[k*W +: W], obs[j-M][(k-1)*W +: W]);
      end
      if (j > N * M)
        chk(last_tap == hist[j-N*M], "R4", "last_tap", last_tap, hist[j-N*M]);
      chk(taps_valid == (j > N * M), "R6", "valid flag", taps_valid, (j > N * M));
    end else begin
      // R3: idle edge leaves every output as it was
      chk(taps_out == prv_taps,   "R3", "idle taps", taps_out, prv_taps);
      chk(last_tap == prv_last,   "R3", "idle last", last_tap, prv_last);
      chk(taps_valid == prv_valid, "R3", "idle valid", taps_valid, prv_valid);
    end
    prv_taps  = taps_out;
    prv_last  = last_tap;
    prv_valid = taps_valid;
  endtask

  initial begin
    void'($urandom(32'd7071));
    @(negedge clk);
    // R5: reset with shift_en high must not count as a shift
    repeat (3) cycle(1'b1, 1'b1, 8'hAA);
    // directed fill with distinct words, crossing the valid edge (R6)
    for (int i = 0; i < 40; i++) cycle(1'b0, 1'b1, W'(i + 1));
    // idle run with changing din (R3)
    for (int i = 0; i < 12; i++) cycle(1'b0, 1'b0, W'($urandom));
    // resume: R1 shows no gap after the idle run
    for (int i = 0; i < 30; i++) cycle(1'b0, 1'b1, W'(8'h80 + i));
    // random enables and data
    for (int i = 0; i < 1500; i++) cycle(1'b0, ($urandom % 10) < 7, W'($urandom));
    // mid-stream reset, then an exact refill (R5, R6)
    repeat (2) cycle(1'b1, 1'b0, 8'h55);
    for (int i = 0; i < M * N + 3; i++) cycle(1'b0, 1'b1, W'($urandom));
    // alternating enable
    for (int i = 0; i < 60; i++) cycle(1'b0, i[0], W'($urandom));
    for (int i = 0; i < 800; i++) cycle(1'b0, ($urandom % 4) != 0, W'($urandom));
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule